// File: doc/BRIEF.md
# Multi-Phase Averaging Clock Divider

The block divides an input clock by an even ratio (ten by default) and, rather than presenting a single divided edge, presents a whole family of copies of the divided clock. A counter makes a 50% duty square wave at the input frequency over the ratio. That square wave then runs through a retiming chain with as many stages as the ratio. Each stage is its own register. The stages alternate between the rising and the falling input edge, so neighbouring copies sit half an input period apart.

All copies leave the block in parallel on one bus. An external resistive or analog network sums them. Each copy carries a separate sampling of the input timing, so the sum averages out the jitter that a plain divider would discard. This is meant to give an output phase noise that falls with the square of the ratio rather than with the ratio alone.

Reset is asynchronous and active low. Its release is retimed onto the rising input edge inside the block.

Top module: `mpd_avg_divider`

## Requirements
- R1: While `rst_n` is low, every bit of `taps_out` is 0, and asserting `rst_n` clears the bus without waiting for a clock edge.
- R2: After `rst_n` goes high, count the rising input edges seen with `rst_n` high as 1, 2, 3, and so on. The first is rising edge 1. `taps_out[0]` first goes high right after rising edge RATIO/2+3: two edges of reset retiming, RATIO/2 counting edges, and one edge of retiming.
- R3: `taps_out[0]` is a square wave that changes only on rising input edges. Each level lasts exactly RATIO/2 input cycles, so its period is RATIO input cycles.
- R4: For every k ≥ 1, `taps_out[k]` equals `taps_out[k-1]` delayed by one half input period. Even-indexed bits change only on rising input edges and odd-indexed bits only on falling input edges.
- R5: Bit 0 is the earliest copy. Bit k first rises exactly k half input periods after bit 0 first rises.
- R6: Every tap has the same duty cycle. Over any whole number of output periods, each bit is high for exactly half of the half-period samples.
- R7: Asserting `rst_n` mid-run, even while a divided edge is part-way through the chain, restarts the sequence with the same timing as R2 once `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| taps_out | output | RATIO | Half-period-spaced copies of the divided clock, bit 0 earliest |

## Verification
Reset assertion and a divided edge in flight through the retiming chain can coincide. In that case some taps are already high and others still low, and the clear has to win everywhere at once. The bench provokes this by waiting for bit 0 to rise and then pulling `rst_n` low two input cycles later, so the wavefront is half-way along the bus. The bench judges the result in two ways. First, it samples after every edge and expects the whole bus at zero. Second, it checks that the first rise of every tap after the new release falls on the same edge and half-period offsets that a fresh start gives.

// File: rtl/mpd_avg_pkg.sv
package mpd_avg_pkg;

  // Default divide ratio; must be even and at least 2.
  localparam int unsigned DEF_RATIO = 10;

  // Counter width needed to count to n-1 (never below one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mpd_reset_sync.sv
// Asynchronous assertion, release retimed onto the rising clock edge.
module mpd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/mpd_div_counter.sv
// Divide-by-RATIO square wave: level toggles every RATIO/2 rising edges.
module mpd_div_counter
  import mpd_avg_pkg::*;
#(
  parameter int unsigned RATIO = DEF_RATIO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  output logic div_o
);

  localparam int unsigned HALF = RATIO / 2;
  localparam int unsigned CW   = cnt_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (cnt_en) begin
      if (wrap) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign div_o = lvl_q;

endmodule

// File: rtl/mpd_tap_chain.sv
// Retiming chain: one register per tap, even stages on the rising edge,
// odd stages on the falling edge, giving half-period spacing.
module mpd_tap_chain #(
  parameter int unsigned TAPS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  output logic [TAPS-1:0] taps_o
);

  logic [TAPS-1:0] stage_v;

  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    logic src;
    logic q_r;

    if (k == 0) begin : g_head
      assign src = din;
    end else begin : g_link
      assign src = stage_v[k-1];
    end

    if ((k % 2) == 0) begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= 1'b0;
        end else begin
          q_r <= src;
        end
      end
    end else begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= 1'b0;
        end else begin
          q_r <= src;
        end
      end
    end

    assign stage_v[k] = q_r;
  end

  assign taps_o = stage_v;

endmodule

// File: rtl/mpd_avg_divider.sv
module mpd_avg_divider
  import mpd_avg_pkg::*;
#(
  parameter int unsigned RATIO = DEF_RATIO
) (
  input  logic             clk_in,
  input  logic             rst_n,
  output logic [RATIO-1:0] taps_out
);

  logic rst_int_n;
  logic div_sq;

  mpd_reset_sync #(
    .STAGES (2)
  ) u_rst (
    .clk     (clk_in),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  mpd_div_counter #(
    .RATIO (RATIO)
  ) u_div (
    .clk    (clk_in),
    .rst_n  (rst_int_n),
    .cnt_en (1'b1),
    .div_o  (div_sq)
  );

  mpd_tap_chain #(
    .TAPS (RATIO)
  ) u_chain (
    .clk    (clk_in),
    .rst_n  (rst_int_n),
    .din    (div_sq),
    .taps_o (taps_out)
  );

endmodule

// File: rtl/mpd_avg_divider_chk.sv
module mpd_avg_divider_chk #(
  parameter int unsigned RATIO = 10
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic [RATIO-1:0] taps_out
);

  localparam int unsigned HALF = RATIO / 2;

  logic prev0;
  logic seen0;
  int   gap;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      prev0 <= 1'b0;
      seen0 <= 1'b0;
      gap   <= 0;
    end else begin
      prev0 <= taps_out[0];
      if (taps_out[0] != prev0) begin
        gap   <= 1;
        seen0 <= 1'b1;
      end else begin
        gap <= gap + 1;
      end
    end
  end

  // R1: the bus is clear while reset is held.
  assert_reset_clear_R1: assert property (@(posedge clk_in)
    (!rst_n && !$past(rst_n)) |-> (taps_out == '0));

  // R3: after the first change, bit 0 holds each level for HALF rising edges.
  assert_tap0_period_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
    (seen0 && (taps_out[0] != prev0)) |-> (gap == HALF));

  for (genvar j = 1; j < RATIO; j++) begin : g_spacing
    if ((j % 2) == 0) begin : g_even
      // R4: an even tap takes, at a rising edge, what its odd neighbour held.
      assert_even_follows_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        taps_out[j] == $past(taps_out[j-1]));
    end else begin : g_odd
      // R4: an odd tap takes, at a falling edge, what its even neighbour held.
      assert_odd_follows_R4: assert property (@(negedge clk_in) disable iff (!rst_n)
        taps_out[j] == $past(taps_out[j-1]));
    end
  end

endmodule

bind mpd_avg_divider mpd_avg_divider_chk #(
  .RATIO (RATIO)
) u_chk (
  .clk_in   (clk_in),
  .rst_n    (rst_n),
  .taps_out (taps_out)
);

// File: tb/mpd_avg_divider_test.sv
`timescale 1ns/1ps
module mpd_avg_divider_test;

  localparam int RATIO = 10;
  localparam int HALF  = RATIO / 2;

  logic             clk_in;
  logic             rst_n;
  logic [RATIO-1:0] taps_out;

  int compared;
  int mismatched;

  mpd_avg_divider #(.RATIO(RATIO)) uut (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .taps_out (taps_out)
  );

  initial clk_in = 1'b0;
  always #5 clk_in = ~clk_in;

  // Reference model state
  int rel;
  int hs;
  int run_no;
  bit tap0m;
  bit hist[$];
  int rise_hs[RATIO];
  bit win_on;
  bit win_done;
  int win_left;
  int hi_cnt[RATIO];

  function automatic bit div_at(input int n);
    int m;
    m = n - 2;
    if (m <= 0) return 1'b0;
    return bit'((m / HALF) % 2);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, expv);
    end
  endtask

  task automatic clear_model();
    rel    = 0;
    hs     = 0;
    tap0m  = 1'b0;
    hist.delete();
    for (int k = 0; k < RATIO; k++) begin
      hist.push_back(1'b0);
      rise_hs[k] = -1;
      hi_cnt[k]  = 0;
    end
    win_on   = 1'b0;
    win_done = 1'b0;
    win_left = 0;
  endtask

  task automatic sample_step(input bit rise, input bit edge_rst);
    logic [RATIO-1:0] expv;
    if (!rst_n || !edge_rst) begin
      clear_model();
      chk(taps_out == '0, "R1", taps_out, 0);
    end else begin
      if (rise) begin
        rel++;
        tap0m = div_at(rel - 1);
      end
      hist.push_back(tap0m);
      void'(hist.pop_front());
      hs++;
      for (int k = 0; k < RATIO; k++) expv[k] = hist[RATIO - 1 - k];
      chk(taps_out[0] == expv[0], "R3", taps_out[0], expv[0]);
      chk(taps_out[RATIO-1:1] == expv[RATIO-1:1], "R4", taps_out, expv);
      for (int k = 0; k < RATIO; k++) begin
        if (rise_hs[k] < 0 && taps_out[k]) begin
          rise_hs[k] = hs;
          if (k == 0)
            chk(rise && rel == HALF + 3, (run_no == 2) ? "R7" : "R2", rel, HALF + 3);
          else
            chk(rise_hs[0] >= 0 && hs - rise_hs[0] == k, "R5", hs - rise_hs[0], k);
        end
      end
      if (rise && rel == HALF + 3 + RATIO && !win_on && !win_done) begin
        win_on   = 1'b1;
        win_left = 8 * RATIO;
        for (int k = 0; k < RATIO; k++) hi_cnt[k] = 0;
      end
      if (win_on) begin
        for (int k = 0; k < RATIO; k++) hi_cnt[k] += int'(taps_out[k]);
        win_left--;
        if (win_left == 0) begin
          win_on   = 1'b0;
          win_done = 1'b1;
          for (int k = 0; k < RATIO; k++)
            chk(hi_cnt[k] == 4 * RATIO, "R6", hi_cnt[k], 4 * RATIO);
        end
      end
    end
  endtask

  // Sampler: a quarter period after every clock edge
  initial begin
    bit er;
    bit rs;
    clear_model();
    #21;
    forever begin
      @(clk_in);
      er = rst_n;
      rs = clk_in;
      #2.5;
      sample_step(rs, er);
    end
  end

  // Stimulus
  initial begin
    compared   = 0;
    mismatched = 0;
    run_no     = 1;
    rst_n      = 1'b0;
    repeat (4) @(posedge clk_in);
    #1 rst_n = 1'b1;
    repeat (80) @(posedge clk_in);
    // R7: reset while the divided edge is part-way down the chain
    @(posedge taps_out[0]);
    repeat (2) @(posedge clk_in);
    #1 rst_n = 1'b0;
    run_no = 2;
    repeat (4) @(posedge clk_in);
    #1 rst_n = 1'b1;
    repeat (80) @(posedge clk_in);
    #4;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // Watchdog
  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog at %0t: actual running expected finished", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule